// File: doc/BRIEF.md
# Manchester Receive Nibble Decoder

This block turns a stream of Manchester half-bit samples into a nibble-wide receive interface. An upstream clock-recovery stage supplies one clean sample per half-bit, marked by a one-cycle strobe at twice the bit rate. A bit cell is two half-bits. The bit value is the second half, so a one arrives as low-then-high and a zero as high-then-low. The block looks for the preamble, sets cell and nibble alignment from it, and packs the decoded bits into nibbles. It also produces a receive clock at one eighth of the strobe rate. Every output change falls on that clock's falling edge, so a downstream MAC can sample on the rising edge.

While the block is receiving, any cell whose two halves match counts as a coding violation. A violation raises a sticky error flag. Reception ends in one of two ways: a nibble slot that holds the terminator half-bits 1,1,1,1,0,0,0,0, or a run of zero half-bits that shows the line has gone quiet. In either case the nibble slot where the end is seen is dropped, and the valid and error flags both fall.

Top module: `mrx_decoder`

## Requirements
- R1: `halfBit` is taken only on clock edges where `halfStb` is high; values on `halfBit` at other edges have no effect on any output.
- R2: `rxValid` rises only after the last eight half-bits form four alternating preamble bits 1,0,1,0 (half-bits 0,1,1,0,0,1,1,0, oldest first). In the same edge `rxNibble` becomes 0x5, which is those four bits.
- R3: After acquisition each following group of four bit cells is delivered as one nibble, first-received bit in bit 0. The bit value is the second half-bit of its cell.
- R4: During reception `rxClk` is low for four strobes and high for four strobes (strobe rate divided by 8), with its phase restarted low at acquisition.
- R5: `rxNibble`, `rxValid` and `rxErr` change only at a strobe that leaves `rxClk` low. A nibble is therefore stable at the rising edge of `rxClk` that follows its delivery.
- R6: A cell with two equal half-bits during reception sets `rxErr` together with the nibble that holds it. `rxErr` stays high until `rxValid` falls.
- R7: A nibble slot whose eight half-bits are 1,1,1,1,0,0,0,0 ends reception. At the end of that slot `rxValid` falls and the slot is not delivered.
- R8: Eight consecutive zero half-bits during reception end it at the end of the current nibble slot, and that slot is not delivered.
- R9: While `rxValid` is low, `rxNibble` is 0 and `rxErr` is low.
- R10: After reset `rxValid`, `rxErr`, `rxClk` and `rxNibble` are all zero.
- R11: Fewer than four preamble bits followed by silence never raise `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfStb | input | 1 | One-cycle strobe marking a valid half-bit sample |
| halfBit | input | 1 | Half-bit sample, taken when `halfStb` is high |
| rxNibble | output | NIB_BITS | Decoded nibble, bit 0 received first |
| rxClk | output | 1 | Receive clock, strobe rate divided by 8 |
| rxValid | output | 1 | Reception in progress |
| rxErr | output | 1 | Coding violation seen during this reception |

## Verification
Each output register updates on the clock edge that takes a strobe, so every flag is due one clock after that strobe. A delivered nibble is held until the next rising edge of `rxClk`, four strobes (twenty clocks with one strobe per five clocks) after the delivery edge. The bench drives strobes and samples outputs on falling clock edges. It records nibble and error values at each rising edge of `rxClk` while `rxValid` is high, measures forty clocks between those edges, and compares the record against the bit list it built for the frame. Valid, error and count checks run only after the idle gap that follows each frame, which is long enough for the ending slot to close.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acquire;  // preamble prefix found: start reception
    logic cellEnd;  // second half of a bit cell taken
    logic deliver;  // last cell of a nibble slot: publish nibble
    logic finish;   // nibble slot closed on an end condition
  } rxStb_t;

  // pattern detections from datapath to control
  typedef struct packed {
    logic preHit;
    logic termHit;
    logic zeroHit;
  } rxSeen_t;

endpackage

// File: rtl/mrx_datapath.sv
module mrx_datapath
  import mrx_pkg::*;
#(
  parameter int NB   = 4,
  parameter int ZRUN = 8,
  localparam int WIN = 2 * NB,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int ZW  = $clog2(ZRUN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          halfStb,
  input  logic          halfBit,
  input  rxStb_t        stb,
  input  logic [BW-1:0] bitIdx,
  output rxSeen_t       seen,
  output logic [NB-1:0] rxNibble,
  output logic          rxValid,
  output logic          rxErr
);

  // alternating preamble bits 1,0,1,0..., each sent as (~b, b), oldest in MSB
  function automatic logic [WIN-1:0] prePattern();
    logic [WIN-1:0] p;
    p = '0;
    for (int i = 0; i < NB; i++) begin
      p[WIN-1-2*i] = (i % 2 != 0);
      p[WIN-2-2*i] = (i % 2 == 0);
    end
    return p;
  endfunction

  function automatic logic [NB-1:0] preNibble();
    logic [NB-1:0] n;
    for (int i = 0; i < NB; i++) n[i] = (i % 2 == 0);
    return n;
  endfunction

  localparam logic [WIN-1:0] PRE_PAT  = prePattern();
  localparam logic [WIN-1:0] TERM_PAT = {{NB{1'b1}}, {NB{1'b0}}};
  localparam logic [NB-1:0]  PRE_NIB  = preNibble();

  logic [WIN-1:0] win, winNext;
  logic [ZW-1:0]  zeroCnt, zeroCntNext;
  logic           zeroLatch;
  logic [NB-1:0]  bitAcc, assembled;
  logic           violAcc;
  logic           cellViol;

  assign winNext  = {win[WIN-2:0], halfBit};
  assign cellViol = (win[0] == halfBit);

  always_comb begin
    if (halfBit) zeroCntNext = '0;
    else if (zeroCnt == ZW'(ZRUN)) zeroCntNext = zeroCnt;
    else zeroCntNext = zeroCnt + 1'b1;
  end

  always_comb begin
    assembled = bitAcc;
    assembled[bitIdx] = halfBit;
  end

  assign seen.preHit  = halfStb && (winNext == PRE_PAT);
  assign seen.termHit = halfStb && (winNext == TERM_PAT);
  assign seen.zeroHit = zeroLatch || (halfStb && (zeroCntNext == ZW'(ZRUN)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win     <= '0;
      zeroCnt <= '0;
    end else if (halfStb) begin
      win     <= winNext;
      zeroCnt <= zeroCntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxNibble  <= '0;
      rxValid   <= 1'b0;
      rxErr     <= 1'b0;
      bitAcc    <= '0;
      violAcc   <= 1'b0;
      zeroLatch <= 1'b0;
    end else if (stb.acquire) begin
      rxNibble  <= PRE_NIB;
      rxValid   <= 1'b1;
      rxErr     <= 1'b0;
      bitAcc    <= '0;
      violAcc   <= 1'b0;
      zeroLatch <= 1'b0;
    end else if (stb.finish) begin
      rxNibble  <= '0;
      rxValid   <= 1'b0;
      rxErr     <= 1'b0;
      violAcc   <= 1'b0;
      zeroLatch <= 1'b0;
    end else begin
      if (rxValid && halfStb && (zeroCntNext == ZW'(ZRUN))) zeroLatch <= 1'b1;
      if (stb.deliver) begin
        rxNibble <= assembled;
        rxErr    <= rxErr | violAcc | cellViol;
        violAcc  <= 1'b0;
      end else if (stb.cellEnd) begin
        bitAcc[bitIdx] <= halfBit;
        violAcc        <= violAcc | cellViol;
      end
    end
  end

  // R9: quiet outputs when not receiving
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> (rxNibble == '0 && !rxErr));

  // R2: reception starts only on the preamble prefix
  p_acq_pattern_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> (win == PRE_PAT && rxNibble == PRE_NIB));

  // R6: error is sticky while valid stays high
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(rxValid) && $past(rxErr)) |-> rxErr);

  // R7 / R8: reception ends only on terminator or zero run
  p_end_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxValid) |-> (win == TERM_PAT || $past(zeroLatch) || zeroCnt == ZW'(ZRUN)));

endmodule

// File: rtl/mrx_control.sv
module mrx_control
  import mrx_pkg::*;
#(
  parameter int NB = 4,
  localparam int HALVES = 2 * NB,
  localparam int HW = $clog2(HALVES),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          halfStb,
  input  rxSeen_t       seen,
  output rxStb_t        stb,
  output logic [BW-1:0] bitIdx,
  output logic          rxClk
);

  rxState_t       state;
  logic [HW-1:0]  hp, hpNext;
  logic           lastSlot;

  assign lastSlot = (hp == HW'(HALVES - 1));
  assign bitIdx   = BW'(hp >> 1);

  always_comb begin
    stb = '0;
    if (state == ST_HUNT) begin
      stb.acquire = seen.preHit;
    end else if (halfStb) begin
      stb.cellEnd = hp[0];
      if (lastSlot) begin
        if (seen.termHit || seen.zeroHit) stb.finish = 1'b1;
        else stb.deliver = 1'b1;
      end
    end
  end

  always_comb begin
    if (stb.acquire) hpNext = '0;
    else if (halfStb) hpNext = lastSlot ? '0 : hp + 1'b1;
    else hpNext = hp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HUNT;
      hp    <= '0;
      rxClk <= 1'b0;
    end else begin
      hp    <= hpNext;
      rxClk <= (hpNext >= HW'(HALVES / 2));
      if (stb.acquire) state <= ST_RECV;
      else if (stb.finish) state <= ST_HUNT;
    end
  end

  // R1: no strobe, no phase movement
  p_hold_no_stb_r1: assert property (@(posedge clk) disable iff (!rstN)
    !halfStb |=> $stable(hp));

  // R5: a nibble is published on the falling edge of the receive clock
  p_deliver_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.deliver |=> (!rxClk && $past(rxClk)));

  // R4: acquisition restarts the receive clock phase low
  p_acq_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.acquire |=> (hp == '0 && !rxClk));

endmodule

// File: rtl/mrx_decoder.sv
module mrx_decoder #(
  parameter int NIB_BITS = 4,
  parameter int ZERO_RUN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                halfStb,
  input  logic                halfBit,
  output logic [NIB_BITS-1:0] rxNibble,
  output logic                rxClk,
  output logic                rxValid,
  output logic                rxErr
);
  import mrx_pkg::*;

  localparam int BW = (NIB_BITS > 1) ? $clog2(NIB_BITS) : 1;

  rxStb_t        stb;
  rxSeen_t       seen;
  logic [BW-1:0] bitIdx;

  mrx_control #(.NB(NIB_BITS)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .halfStb(halfStb),
    .seen   (seen),
    .stb    (stb),
    .bitIdx (bitIdx),
    .rxClk  (rxClk)
  );

  mrx_datapath #(.NB(NIB_BITS), .ZRUN(ZERO_RUN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .halfStb (halfStb),
    .halfBit (halfBit),
    .stb     (stb),
    .bitIdx  (bitIdx),
    .seen    (seen),
    .rxNibble(rxNibble),
    .rxValid (rxValid),
    .rxErr   (rxErr)
  );

  // R5: outputs move only while the receive clock is low
  p_change_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rxNibble) || !$stable(rxValid)) |-> !rxClk);

endmodule

// File: tb/mrx_decoder_tb.sv
module mrx_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfStb = 1'b0;
  logic       halfBit = 1'b0;
  logic [3:0] rxNibble;
  logic       rxClk, rxValid, rxErr;

  int checks = 0;
  int errors = 0;

  logic [3:0] capNib[64];
  logic       capErr[64];
  int         capN = 0;
  bit         sawValid = 0;
  longint     cyc = 0;
  longint     lastRise = -1;
  logic       prevClk = 0, prevValid = 0, prevErr = 0;
  logic [3:0] prevNib = 0;

  always #5 clk = ~clk;

  mrx_decoder u_dut (
    .clk(clk), .rstN(rstN), .halfStb(halfStb), .halfBit(halfBit),
    .rxNibble(rxNibble), .rxClk(rxClk), .rxValid(rxValid), .rxErr(rxErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor on falling edges
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (rxValid) sawValid = 1;
      // R5: changes only while rxClk low
      if (rxNibble != prevNib || rxValid != prevValid || rxErr != prevErr)
        chk(rxClk == 1'b0, "R5 change with rxClk high", rxClk, 0);
      if (rxClk && !prevClk) begin
        if (rxValid) begin
          if (capN < 64) begin
            capNib[capN] = rxNibble;
            capErr[capN] = rxErr;
            capN++;
          end
          // R4: 8 strobes of 5 clocks between rising edges
          if (lastRise >= 0) chk(cyc - lastRise == 40, "R4 rxClk period", int'(cyc - lastRise), 40);
          lastRise = cyc;
        end else begin
          lastRise = -1;
          // R9: quiet outputs when idle
          chk(rxNibble == 0 && !rxErr, "R9 idle outputs", {rxErr, rxNibble}, 0);
        end
      end
      prevClk = rxClk; prevNib = rxNibble; prevValid = rxValid; prevErr = rxErr;
    end
  end

  // one strobe per five clocks; halfBit scrambled between strobes (R1)
  task automatic sendHalf(input logic b);
    @(negedge clk); halfStb = 1'b1; halfBit = b;
    @(negedge clk); halfStb = 1'b0; halfBit = 1'($urandom);
    repeat (3) begin @(negedge clk); halfBit = 1'($urandom); end
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendHalf(1'b0);
  endtask

  // preNibs preamble nibbles, dataN data nibbles, violation at nibble violAt (-1 none)
  task automatic runFrame(input int preNibs, input int dataN, input int violAt, input bit endTerm);
    logic [3:0] expNib[16];
    logic       expErr[16];
    int         total, vBit;
    logic       vVal;
    total = preNibs + dataN;
    vBit = int'($urandom % 4);
    vVal = 1'($urandom);
    for (int k = 0; k < total; k++) begin
      expNib[k] = (k < preNibs) ? 4'h5 : 4'($urandom);
      expErr[k] = (violAt >= 0) && (k >= violAt);
    end
    capN = 0;
    for (int k = 0; k < total; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (k == violAt && j == vBit) begin
          sendHalf(vVal); sendHalf(vVal);
          expNib[k][j] = vVal;
        end else begin
          sendHalf(~expNib[k][j]); sendHalf(expNib[k][j]);
        end
      end
    end
    if (endTerm) begin
      sendHalf(1); sendHalf(1); sendHalf(1); sendHalf(1);
      sendZeros(4);
    end else begin
      sendZeros(8);
    end
    sendZeros(8 + int'($urandom % 8));
    // R7 / R8: slot with end condition not delivered, reception ended
    chk(capN == total, endTerm ? "R7 nibble count" : "R8 nibble count", capN, total);
    chk(rxValid == 0, endTerm ? "R7 valid fell" : "R8 valid fell", rxValid, 0);
    chk(rxErr == 0, "R6 error cleared", rxErr, 0);
    for (int k = 0; k < total && k < capN; k++) begin
      // R2 (first nibble), R3 packing, R1 off-strobe noise ignored
      chk(capNib[k] == expNib[k], (k == 0) ? "R2 first nibble" : "R3 R1 nibble value",
          capNib[k], expNib[k]);
      chk(capErr[k] == expErr[k], "R6 error flag", capErr[k], expErr[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rxValid == 0 && rxErr == 0 && rxClk == 0 && rxNibble == 0, "R10 reset outputs",
        {rxValid, rxErr, rxClk, rxNibble}, 0);
    @(negedge clk); rstN = 1'b1;
    sendZeros(10);

    // R11: three preamble bits then silence
    sawValid = 0;
    sendHalf(0); sendHalf(1); sendHalf(1); sendHalf(0); sendHalf(0); sendHalf(1);
    sendZeros(16);
    chk(sawValid == 0, "R11 short preamble", sawValid, 0);

    // directed: minimum preamble, terminator end (R7)
    runFrame(1, 2, -1, 1);
    // directed: zero-run end (R8)
    runFrame(2, 3, -1, 0);
    // directed: violation in first data nibble (R6)
    runFrame(2, 4, 2, 1);
    // directed: violation in last data nibble, zero-run end
    runFrame(1, 3, 3, 0);

    for (int f = 0; f < 24; f++) begin
      int pre, dat, va;
      pre = 1 + int'($urandom % 4);
      dat = 1 + int'($urandom % 8);
      va  = ($urandom % 3 == 0) ? pre + int'($urandom % dat) : -1;
      runFrame(pre, dat, va, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule